// File: doc/BRIEF.md
# Reset Sequencing Controller for a Supply Supervisor

This block turns a supply-good flag and the sensed level of a shared reset pin into a clean, minimum-length system reset. The supply-good flag comes from an external comparator and is already synchronized to the block's clock. The reset pin is open-drain and bidirectional: the block pulls it low through an enable output, and outside logic or a push button may also pull it low. A third output holds a serial memory interface in lockout for as long as reset is active. Lockout aborts a serial transfer in progress and refuses to start a new write, but the block never touches an internal nonvolatile write cycle that is already under way.

Both inputs pass through stability filters. The filters reject brief low glitches on the supply flag and brief low pulses on the pin. A controller with three states (`ST_SUPPLY_LOW`, `ST_TIMEOUT`, `ST_RUN`) sequences the outputs:
- `ST_SUPPLY_LOW` goes to `ST_TIMEOUT` when the filtered supply becomes good (transition *supply_up*).
- `ST_TIMEOUT` goes to `ST_RUN` when the timeout counter completes (*timeout_done*).
- `ST_TIMEOUT` and `ST_RUN` both go back to `ST_SUPPLY_LOW` when the filtered supply drops (*supply_drop*).
- `ST_RUN` goes to `ST_TIMEOUT` on a filtered falling edge of the pin (*manual_edge*).

Manual-edge detection is armed only in `ST_RUN`. The block therefore never retriggers on the low level it drives onto the pin itself. The timeout length and both filter lengths are parameters given in clock cycles.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n` is low, `rst_o`, `pin_drive_low_o` and `ser_lock_o` are 1 and `wr_start_o` is 0. The controller leaves reset in `ST_SUPPLY_LOW`.
- R2: A low level on `supply_ok_i` that lasts at least `SUP_FILT` cycles asserts `rst_o` exactly `SUP_FILT`+1 rising edges after the first edge that samples it low. `rst_o` stays high while the supply stays low.
- R3: After `supply_ok_i` rises and stays high, `rst_o` falls exactly `SUP_FILT`+`TIMEOUT_CYC`+1 rising edges after the first edge that samples it high.
- R4: A low pulse on `supply_ok_i` that lasts fewer than `SUP_FILT` cycles does not assert `rst_o`.
- R5: If the supply drops during an active timeout, the timeout restarts from zero. After recovery, release again takes `SUP_FILT`+`TIMEOUT_CYC`+1 edges.
- R6: In `ST_RUN`, a low level on `pin_sense_i` that lasts at least `PIN_FILT` cycles asserts `rst_o` `PIN_FILT`+1 edges after it is first sampled. Reset then lasts exactly `TIMEOUT_CYC` cycles, whether the outside pulse is shorter or longer than that.
- R7: A low pulse on `pin_sense_i` that lasts fewer than `PIN_FILT` cycles does not assert `rst_o`.
- R8: After release, the pin's own return from the driven low level causes no new reset. `rst_o` stays 0 while the inputs are quiet.
- R9: `ser_lock_o` equals `rst_o` in every cycle. `wr_start_o` is `wr_req_i` when lockout is low and 0 when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset of the controller's flops |
| supply_ok_i | input | 1 | Synchronized supply-good flag, 1 = supply above threshold |
| pin_sense_i | input | 1 | Sensed level of the reset pin, 0 = pulled low |
| wr_req_i | input | 1 | Request from the serial engine to start an internal write |
| pin_drive_low_o | output | 1 | Open-drain enable, 1 = pull the reset pin low |
| rst_o | output | 1 | Active-high reset |
| ser_lock_o | output | 1 | Serial interface lockout, 1 = abort transfers and refuse new ones |
| wr_start_o | output | 1 | Gated start for a new internal write cycle |

## Verification
The bench modelling the pin as a wired-AND of the outside driver and `pin_drive_low_o`. It tries supply-low pulses one cycle shorter than the filter, equal to it, and longer. The same is done for the pin filter, which separates rejected glitches from accepted events right at the boundary. Exact edge counts for power-up, power-down, and a supply drop inside a running timeout tell a correct restart apart from a continued count or an off-by-one timeout. Two manual pulses, one much shorter and one longer than the timeout, show that the reset length is fixed and that the block's own drive does not retrigger it.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        ST_SUPPLY_LOW = 2'd0,
        ST_TIMEOUT    = 2'd1,
        ST_RUN        = 2'd2
    } seq_state_e;

endpackage

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
    parameter int unsigned N       = 4,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic q;

    generate
        if (N <= 1) begin : g_pass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
        end else begin : g_count
            localparam int unsigned CW = $clog2(N);
            logic [CW-1:0] run_len;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q       <= RST_VAL;
                    run_len <= '0;
                end else if (din == q) begin
                    run_len <= '0;
                end else if (run_len == CW'(N - 1)) begin
                    q       <= din;
                    run_len <= '0;
                end else begin
                    run_len <= run_len + 1'b1;
                end
            end
        end
    endgenerate

    assign dout = q;

    // R4 / R7: the output only ever moves to the level the input last held
    p_follow_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(din) == dout));

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int unsigned LEN = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else if (cnt != CW'(LEN - 1)) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == CW'(LEN - 1));

    // R3: the count never passes the programmed length
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LEN - 1));

    // R5: leaving the timeout clears the count
    p_clear_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 40_000_000,
    parameter int unsigned SUP_FILT    = 8,
    parameter int unsigned PIN_FILT    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic pin_sense_i,
    input  logic wr_req_i,
    output logic pin_drive_low_o,
    output logic rst_o,
    output logic ser_lock_o,
    output logic wr_start_o
);

    seq_state_e state_q, state_d;
    logic       sup_f;
    logic       pin_f;
    logic       pin_prev;
    logic       pin_fall;
    logic       tmr_done;

    rstseq_filter #(.N(SUP_FILT), .RST_VAL(1'b0)) u_sup_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (supply_ok_i),
        .dout  (sup_f)
    );

    rstseq_filter #(.N(PIN_FILT), .RST_VAL(1'b1)) u_pin_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_sense_i),
        .dout  (pin_f)
    );

    rstseq_timer #(.LEN(TIMEOUT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_TIMEOUT),
        .done  (tmr_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= 1'b1;
        else        pin_prev <= pin_f;
    end

    // Armed only while released, so the block's own drive cannot retrigger it
    assign pin_fall = pin_prev && !pin_f && (state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SUPPLY_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPPLY_LOW: if (sup_f)    state_d = ST_TIMEOUT;    // supply_up
            ST_TIMEOUT: begin
                if (!sup_f)              state_d = ST_SUPPLY_LOW; // supply_drop
                else if (tmr_done)       state_d = ST_RUN;        // timeout_done
            end
            ST_RUN: begin
                if (!sup_f)              state_d = ST_SUPPLY_LOW; // supply_drop
                else if (pin_fall)       state_d = ST_TIMEOUT;    // manual_edge
            end
            default:                     state_d = ST_SUPPLY_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN: begin
                rst_o           = 1'b0;
                pin_drive_low_o = 1'b0;
                ser_lock_o      = 1'b0;
            end
            default: begin
                rst_o           = 1'b1;
                pin_drive_low_o = 1'b1;
                ser_lock_o      = 1'b1;
            end
        endcase
        wr_start_o = wr_req_i && !ser_lock_o;
    end

    // R2: an accepted supply drop forces reset on the next cycle
    p_drop_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sup_f) |=> rst_o);

    // R3: release only follows a completed timeout
    p_release_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> $past(tmr_done));

    // R5: a drop during the timeout abandons it
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMEOUT && !sup_f) |=> (state_q == ST_SUPPLY_LOW));

    // R8: released state holds without a supply drop or a manual edge
    p_run_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sup_f && !pin_fall) |=> !rst_o);

    // R9: no new write start while the lockout is high
    p_no_start_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_lock_o |-> !wr_start_o);

endmodule

// File: tb/test_rstseq_top.sv
`timescale 1ns/1ps
module test_rstseq_top;

    localparam int T  = 50;
    localparam int SF = 4;
    localparam int PF = 20;

    // [9] kind (0 supply, 1 pin), [8] reset expected, [7:0] low length
    localparam logic [9:0] VEC [8] = '{
        {1'b0, 1'b0, 8'd1},  {1'b0, 1'b0, 8'd3},
        {1'b0, 1'b1, 8'd4},  {1'b0, 1'b1, 8'd6},
        {1'b1, 1'b0, 8'd5},  {1'b1, 1'b0, 8'd19},
        {1'b1, 1'b1, 8'd20}, {1'b1, 1'b1, 8'd25}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply = 1'b0;
    logic ext_pin = 1'b1;
    logic wr_req = 1'b1;
    logic pin_sense;
    logic pin_drive_low, rst_o, ser_lock, wr_start;
    int   tests = 0;
    int   fails = 0;
    int   lock_bad = 0;

    always #2.5 clk = ~clk;

    assign pin_sense = ext_pin & ~pin_drive_low;

    rstseq_top #(.TIMEOUT_CYC(T), .SUP_FILT(SF), .PIN_FILT(PF)) i_rstseq_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .supply_ok_i     (supply),
        .pin_sense_i     (pin_sense),
        .wr_req_i        (wr_req),
        .pin_drive_low_o (pin_drive_low),
        .rst_o           (rst_o),
        .ser_lock_o      (ser_lock),
        .wr_start_o      (wr_start)
    );

    // R9 lockout tracking
    always @(negedge clk) begin
        if (rst_n && (ser_lock !== rst_o || wr_start !== (wr_req & ~ser_lock)))
            lock_bad = lock_bad + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        while (rst_o !== lvl && n < 10000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic quiet_high(input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rst_o !== 1'b0) hits++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual expired expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        int hits;
        bit seen;
        repeat (3) @(negedge clk);
        check("R1 rst", rst_o, 1);
        check("R1 drive", pin_drive_low, 1);
        check("R1 lock", ser_lock, 1);
        check("R1 wr_start", wr_start, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R2 supply low holds reset", rst_o, 1);

        supply = 1'b1;
        wait_level(1'b0, n);
        check("R3 power-up edges", n, SF + T + 1);
        check("R9 wr_start after release", wr_start, 1);
        quiet_high(3 * PF, hits);
        check("R8 no self retrigger after power-up", hits, 0);

        // table of glitch and event pulses (R4, R7, R2, R6)
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            if (VEC[v][9]) ext_pin = 1'b0; else supply = 1'b0;
            repeat (int'(VEC[v][7:0])) @(negedge clk);
            ext_pin = 1'b1;
            supply = 1'b1;
            seen = 1'b0;
            for (int i = 0; i < PF + 5; i++) begin
                @(negedge clk);
                if (rst_o) seen = 1'b1;
            end
            check(VEC[v][9] ? (VEC[v][8] ? "R6 pin pulse" : "R7 pin glitch")
                            : (VEC[v][8] ? "R2 supply pulse" : "R4 supply glitch"),
                  seen, VEC[v][8]);
            wait_level(1'b0, n);
            repeat (PF + 5) @(negedge clk);
        end

        // R2 exact assertion time and lockout
        supply = 1'b0;
        wait_level(1'b1, n);
        check("R2 power-down edges", n, SF + 1);
        check("R9 lock on drop", ser_lock, 1);
        check("R9 wr_start blocked", wr_start, 0);

        // R5 drop inside running timeout
        supply = 1'b1;
        repeat (SF + 10) @(negedge clk);
        supply = 1'b0;
        repeat (SF + 2) @(negedge clk);
        check("R5 still reset during drop", rst_o, 1);
        supply = 1'b1;
        wait_level(1'b0, n);
        check("R5 restarted timeout edges", n, SF + T + 1);
        repeat (PF + 5) @(negedge clk);

        // R6 short manual pulse
        ext_pin = 1'b0;
        wait_level(1'b1, n);
        ext_pin = 1'b1;
        check("R6 manual assert edges", n, PF + 1);
        wait_level(1'b0, n);
        check("R6 short pulse full timeout", n, T);
        quiet_high(3 * PF, hits);
        check("R8 no self retrigger after manual", hits, 0);

        // R6 long manual pulse
        ext_pin = 1'b0;
        wait_level(1'b1, n);
        wait_level(1'b0, n);
        check("R6 long pulse fixed timeout", n, T);
        repeat (T) @(negedge clk);
        check("R6 released while pin held", rst_o, 0);
        ext_pin = 1'b1;
        quiet_high(3 * PF, hits);
        check("R8 no reset on pin return", hits, 0);

        check("R9 lockout tracking", lock_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule